// File: doc/BRIEF.md
# Transactional Snoop Responder

In a snoopy multiprocessor node that holds a conventional data cache beside a small transactional cache, this block works out how the node answers a bus request seen from another processor. For each snooped request it looks at the request kind, at the matching line in each cache (its hit flag and coherence state), at the transactional cache line's tag, and at the local flag that says whether the running transaction is still free of conflict. From these it works out the new coherence state for each cache line and one merged reply for the bus: supply data, refuse with BUSY, or stay silent. When the node stays silent and does not refuse, the block raises a flag that main memory must supply the line instead.

The block adds a new rule to an otherwise ordinary write-back snoop scheme. A transactional request that hits a line the transactional cache holds exclusively (dirty or reserved) is refused with BUSY, and the line keeps its state. The requester then backs off and retries instead of stealing the line. The decision is registered, so the reply and next states appear one clock after the snoop is presented.

Top module: `snp_responder`

## Requirements
- R1: Codes: request kind READ=0, RFO=1, T_READ=2, T_RFO=3; line state INVALID=0, VALID=1, DIRTY=2, RESERVED=3; transactional tag EMPTY=0, NORMAL=1, XCOMMIT=2, XABORT=3; reply NONE=0, DATA=1, BUSY=2. In the regular cache a line is present when its hit flag is 1 and its state is not INVALID. A READ or T_READ on a present regular line gives DATA and next state VALID.
- R2: An RFO or T_RFO on a present regular line gives DATA and next state INVALID.
- R3: In the transactional cache a line is present when its hit flag is 1, its state is not INVALID and its tag is not EMPTY. For a READ or RFO, only a present line tagged NORMAL answers: DATA, with next state VALID for READ and INVALID for RFO. A present line with any other tag stays silent and keeps its state.
- R4: When the conflict-free flag is 1, a T_READ or T_RFO on a present transactional line in state VALID gives DATA, whatever the tag. The next state is VALID for T_READ and INVALID for T_RFO.
- R5: When the conflict-free flag is 1, a T_READ or T_RFO on a present transactional line in state DIRTY or RESERVED gives BUSY, whatever the tag, and the line keeps its state.
- R6: When the conflict-free flag is 0, the transactional cache answers T_READ and T_RFO like the regular cache for NORMAL lines. Lines with any other tag ignore the snoop: no reply and no state change.
- R7: If the transactional cache refuses with BUSY while the regular cache would supply data, the merged reply is BUSY.
- R8: If neither cache answers, the reply is NONE and each next state equals its input state. mem_supply_o is 1 exactly when a valid snoop gets reply NONE.
- R9: The reply, mem_supply_o and both next states appear on the clock edge after the snoop is sampled, and rsp_valid_o is the snoop-valid input delayed one cycle. After reset all outputs are 0. A cycle with no snoop gives reply NONE and mem_supply_o of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snoop_valid_i | input | 1 | A snooped request is present this cycle |
| snoop_kind_i | input | 2 | Request kind code |
| reg_hit_i | input | 1 | Regular cache tag match |
| reg_state_i | input | 2 | Regular cache line state |
| tx_hit_i | input | 1 | Transactional cache tag match |
| tx_state_i | input | 2 | Transactional cache line state |
| tx_tag_i | input | 2 | Transactional cache line tag |
| tx_status_i | input | 1 | Local transaction still conflict-free |
| rsp_valid_o | output | 1 | Registered reply is valid |
| rsp_o | output | 2 | Merged reply code |
| mem_supply_o | output | 1 | Main memory must supply the line |
| reg_next_o | output | 2 | Next state for the regular cache line |
| tx_next_o | output | 2 | Next state for the transactional cache line |

## Verification
The hardest case to reach is the one where both caches answer the same snoop. The regular cache must be about to hand over data while the transactional cache, with a conflict-free transaction, holds the same line dirty or reserved. The merged reply must then be BUSY, yet the regular line's state still moves. The bench reaches this case, and every other one, by sweeping every combination of request kind, both hit flags, both states, the tag and the conflict-free flag, one snoop per cycle. For each combination it compares the reply, both next states and the memory flag against values computed from the rules above.

// File: rtl/snp_pkg.sv
// Shared codes for the snoop responder.
// Assumes 2-bit codes for request kind, line state, tag and reply.
package snp_pkg;
    typedef enum logic [1:0] {SK_READ = 2'd0, SK_RFO = 2'd1, SK_TREAD = 2'd2, SK_TRFO = 2'd3} snoop_kind_e;
    typedef enum logic [1:0] {LS_INVALID = 2'd0, LS_VALID = 2'd1, LS_DIRTY = 2'd2, LS_RESERVED = 2'd3} line_state_e;
    typedef enum logic [1:0] {TT_EMPTY = 2'd0, TT_NORMAL = 2'd1, TT_XCOMMIT = 2'd2, TT_XABORT = 2'd3} tx_tag_e;
    typedef enum logic [1:0] {RS_NONE = 2'd0, RS_DATA = 2'd1, RS_BUSY = 2'd2} resp_e;

    // Reply and next state proposed by one cache
    typedef struct packed {
        resp_e       rsp;
        line_state_e nxt;
    } verdict_t;
endpackage

// File: rtl/snp_regular_table.sv
// Snoop table of the regular cache: a present line always supplies data.
// Requests for exclusive ownership invalidate the line; read requests downgrade it to VALID.
// Assumes: purely combinational, evaluated only when the line matched.
module snp_regular_table
    import snp_pkg::*;
(
    input  snoop_kind_e kind_i,
    input  logic        hit_i,
    input  line_state_e state_i,
    output verdict_t    verdict_o
);
    logic present;
    logic excl;

    assign present = hit_i && (state_i != LS_INVALID);
    assign excl    = (kind_i == SK_RFO) || (kind_i == SK_TRFO);

    // Pick the reply and next state from the request kind
    always_comb begin
        verdict_o.rsp = RS_NONE;
        verdict_o.nxt = state_i;
        if (present) begin
            verdict_o.rsp = RS_DATA;
            verdict_o.nxt = excl ? LS_INVALID : LS_VALID;
        end
    end
endmodule

// File: rtl/snp_tx_table.sv
// Snoop table of the transactional cache.
// Plain requests reach only NORMAL lines. Transactional requests from a conflict-free node
// reach lines with any tag: VALID lines are shared out, exclusively held lines refuse with BUSY.
// When the local transaction has seen a conflict, only NORMAL lines answer, as in the regular cache.
// Assumes: purely combinational; a line with tag EMPTY holds no data.
module snp_tx_table
    import snp_pkg::*;
(
    input  snoop_kind_e kind_i,
    input  logic        hit_i,
    input  line_state_e state_i,
    input  tx_tag_e     tag_i,
    input  logic        status_i,
    output verdict_t    verdict_o
);
    logic present;
    logic excl;
    logic tx_req;
    logic normal;

    assign present = hit_i && (state_i != LS_INVALID) && (tag_i != TT_EMPTY);
    assign excl    = (kind_i == SK_RFO) || (kind_i == SK_TRFO);
    assign tx_req  = (kind_i == SK_TREAD) || (kind_i == SK_TRFO);
    assign normal  = (tag_i == TT_NORMAL);

    // Pick the reply and next state from kind, tag, state and the conflict-free flag
    always_comb begin
        verdict_o.rsp = RS_NONE;
        verdict_o.nxt = state_i;
        if (present) begin
            if (tx_req && status_i) begin
                if (state_i == LS_VALID) begin
                    verdict_o.rsp = RS_DATA;
                    verdict_o.nxt = excl ? LS_INVALID : LS_VALID;
                end else begin
                    verdict_o.rsp = RS_BUSY;
                end
            end else if (normal) begin
                verdict_o.rsp = RS_DATA;
                verdict_o.nxt = excl ? LS_INVALID : LS_VALID;
            end
        end
    end
endmodule

// File: rtl/snp_merge.sv
// Merges the two per-cache replies into one bus reply: BUSY wins over DATA, DATA over NONE.
// Memory must step in when a valid snoop draws neither data nor a refusal.
// Assumes: purely combinational.
module snp_merge
    import snp_pkg::*;
(
    input  logic  valid_i,
    input  resp_e reg_rsp_i,
    input  resp_e tx_rsp_i,
    output resp_e rsp_o,
    output logic  mem_o
);
    logic any_busy;
    logic any_data;

    assign any_busy = (reg_rsp_i == RS_BUSY) || (tx_rsp_i == RS_BUSY);
    assign any_data = (reg_rsp_i == RS_DATA) || (tx_rsp_i == RS_DATA);

    // Apply the priority order to the two replies
    always_comb begin
        if (!valid_i)      rsp_o = RS_NONE;
        else if (any_busy) rsp_o = RS_BUSY;
        else if (any_data) rsp_o = RS_DATA;
        else               rsp_o = RS_NONE;
    end

    assign mem_o = valid_i && !any_busy && !any_data;
endmodule

// File: rtl/snp_responder.sv
// Snoop responder top: evaluates both cache tables on a snooped request and registers the
// merged reply, the memory-supply flag and both next line states for one cycle.
// Assumes: synchronous active-low reset; one snoop per cycle; next states hold when idle.
module snp_responder
    import snp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snoop_valid_i,
    input  logic [1:0] snoop_kind_i,
    input  logic       reg_hit_i,
    input  logic [1:0] reg_state_i,
    input  logic       tx_hit_i,
    input  logic [1:0] tx_state_i,
    input  logic [1:0] tx_tag_i,
    input  logic       tx_status_i,
    output logic       rsp_valid_o,
    output logic [1:0] rsp_o,
    output logic       mem_supply_o,
    output logic [1:0] reg_next_o,
    output logic [1:0] tx_next_o
);
    verdict_t reg_v;
    verdict_t tx_v;
    resp_e    merged;
    logic     mem_need;

    snp_regular_table u_reg (
        .kind_i    (snoop_kind_e'(snoop_kind_i)),
        .hit_i     (reg_hit_i),
        .state_i   (line_state_e'(reg_state_i)),
        .verdict_o (reg_v)
    );

    snp_tx_table u_tx (
        .kind_i    (snoop_kind_e'(snoop_kind_i)),
        .hit_i     (tx_hit_i),
        .state_i   (line_state_e'(tx_state_i)),
        .tag_i     (tx_tag_e'(tx_tag_i)),
        .status_i  (tx_status_i),
        .verdict_o (tx_v)
    );

    snp_merge u_merge (
        .valid_i   (snoop_valid_i),
        .reg_rsp_i (reg_v.rsp),
        .tx_rsp_i  (tx_v.rsp),
        .rsp_o     (merged),
        .mem_o     (mem_need)
    );

    // Register the reply and the next states of both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o  <= 1'b0;
            rsp_o        <= 2'd0;
            mem_supply_o <= 1'b0;
            reg_next_o   <= 2'd0;
            tx_next_o    <= 2'd0;
        end else begin
            rsp_valid_o  <= snoop_valid_i;
            rsp_o        <= merged;
            mem_supply_o <= mem_need;
            if (snoop_valid_i) begin
                reg_next_o <= reg_v.nxt;
                tx_next_o  <= tx_v.nxt;
            end
        end
    end

    // R9
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid_o == $past(snoop_valid_i)));

    // R5
    busy_keeps_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_o == 2'd2 && tx_status_i == $past(tx_status_i))
        |-> (tx_next_o == $past(tx_state_i)) && (tx_next_o != 2'd0) && (tx_next_o != 2'd1));

    // R8
    single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_o == 2'd1, rsp_o == 2'd2, mem_supply_o}));

    // R2
    regular_excl_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid_i && reg_hit_i && reg_state_i != 2'd0 && snoop_kind_i[0])
        |=> (reg_next_o == 2'd0) && (rsp_o != 2'd0));

    // R8
    miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid_i && !reg_hit_i && !tx_hit_i)
        |=> (rsp_o == 2'd0) && mem_supply_o && (reg_next_o == $past(reg_state_i)));
endmodule

// File: tb/test_snp_responder.sv
`timescale 1ns/1ps
module test_snp_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       snoop_valid_i = 1'b0;
    logic [1:0] snoop_kind_i = 2'd0;
    logic       reg_hit_i = 1'b0;
    logic [1:0] reg_state_i = 2'd0;
    logic       tx_hit_i = 1'b0;
    logic [1:0] tx_state_i = 2'd0;
    logic [1:0] tx_tag_i = 2'd0;
    logic       tx_status_i = 1'b0;
    logic       rsp_valid_o;
    logic [1:0] rsp_o;
    logic       mem_supply_o;
    logic [1:0] reg_next_o;
    logic [1:0] tx_next_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    snp_responder i_snp_responder (
        .clk(clk), .rst_n(rst_n), .snoop_valid_i(snoop_valid_i), .snoop_kind_i(snoop_kind_i),
        .reg_hit_i(reg_hit_i), .reg_state_i(reg_state_i), .tx_hit_i(tx_hit_i),
        .tx_state_i(tx_state_i), .tx_tag_i(tx_tag_i), .tx_status_i(tx_status_i),
        .rsp_valid_o(rsp_valid_o), .rsp_o(rsp_o), .mem_supply_o(mem_supply_o),
        .reg_next_o(reg_next_o), .tx_next_o(tx_next_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        snoop_valid_i = 1'b1;
        reg_hit_i = 1'b1;
        reg_state_i = 2'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9", "reset rsp_valid", int'(rsp_valid_o), 0);
        check("R9", "reset rsp", int'(rsp_o), 0);
        check("R9", "reset mem", int'(mem_supply_o), 0);
        check("R9", "reset reg_next", int'(reg_next_o), 0);
        check("R9", "reset tx_next", int'(tx_next_o), 0);
        rst_n = 1'b1;
        snoop_valid_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R9: idle cycle
        check("R9", "idle rsp_valid", int'(rsp_valid_o), 0);
        check("R9", "idle rsp", int'(rsp_o), 0);
        check("R9", "idle mem", int'(mem_supply_o), 0);

        for (int k = 0; k < 4; k++)
        for (int st = 0; st < 2; st++)
        for (int rh = 0; rh < 2; rh++)
        for (int rs = 0; rs < 4; rs++)
        for (int th = 0; th < 2; th++)
        for (int ts = 0; ts < 4; ts++)
        for (int tg = 0; tg < 4; tg++) begin
            int e_reg, e_tx, reg_r, tx_r, e_rsp, e_mem;
            string tag_r, tag_t, tag_p;
            bit excl;
            excl = (k == 1) || (k == 3);
            // regular cache expectation
            if (rh == 1 && rs != 0) begin
                reg_r = 1;
                e_reg = excl ? 0 : 1;
                tag_r = excl ? "R2" : "R1";
            end else begin
                reg_r = 0;
                e_reg = rs;
                tag_r = "R8";
            end
            // transactional cache expectation
            tx_r = 0;
            e_tx = ts;
            if (th == 0 || ts == 0 || tg == 0) begin
                tag_t = "R8";
            end else if (k >= 2 && st == 1) begin
                if (ts == 1) begin
                    tx_r = 1;
                    e_tx = excl ? 0 : 1;
                    tag_t = "R4";
                end else begin
                    tx_r = 2;
                    tag_t = "R5";
                end
            end else begin
                tag_t = (k < 2) ? "R3" : "R6";
                if (tg == 1) begin
                    tx_r = 1;
                    e_tx = excl ? 0 : 1;
                end
            end
            // merged reply expectation
            if (tx_r == 2) begin
                e_rsp = 2;
                tag_p = (reg_r == 1) ? "R7" : "R5";
            end else if (tx_r == 1 || reg_r == 1) begin
                e_rsp = 1;
                tag_p = (tx_r == 1) ? tag_t : tag_r;
            end else begin
                e_rsp = 0;
                tag_p = "R8";
            end
            e_mem = (e_rsp == 0) ? 1 : 0;

            snoop_valid_i = 1'b1;
            snoop_kind_i = 2'(k);
            reg_hit_i = 1'(rh);
            reg_state_i = 2'(rs);
            tx_hit_i = 1'(th);
            tx_state_i = 2'(ts);
            tx_tag_i = 2'(tg);
            tx_status_i = 1'(st);
            @(posedge clk);
            @(negedge clk);
            check("R9", "rsp_valid", int'(rsp_valid_o), 1);
            check(tag_p, "rsp", int'(rsp_o), e_rsp);
            check("R8", "mem_supply", int'(mem_supply_o), e_mem);
            check(tag_r, "reg_next", int'(reg_next_o), e_reg);
            check(tag_t, "tx_next", int'(tx_next_o), e_tx);
        end

        snoop_valid_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R9: the cycle after the sweep has no snoop
        check("R9", "final idle rsp_valid", int'(rsp_valid_o), 0);
        check("R9", "final idle mem", int'(mem_supply_o), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule